// File: doc/BRIEF.md
# Regulator Power-Up Slot Sequencer

This block releases the enable lines of a group of power rails one after another when the system starts. Each rail is given a 5-bit position on a shared timeline. A 2-bit speed field sets how long each step of that timeline lasts. Time is measured by counting pulses of a 1 µs tick input. When the start level rises, the block latches the positions and the speed. From then on, a rail with position `c` is switched on once `c` full steps have passed.

The position value 31 (all ones) takes a rail out of the automatic sequence, so its enable never rises. A completion flag rises on the same tick that releases the rail with the highest included position. When start falls, every enable and the flag are cleared, and the timeline is rewound.

The enables and the flag are registered. The configuration arrives as plain input ports. Nothing inside the block can be read back by software.

Top module: `rail_slot_sequencer`

## Requirements
- R1: While reset is high, and after it falls, all rail enables and the done flag are low until a sequence is started.
- R2: Positions and speed are captured on the first clock edge that sees start high while the block is idle. Changes to those inputs after that edge have no effect until start has gone low.
- R3: The step length in ticks is BASE_TICKS shifted left by the speed field: 00 gives BASE_TICKS (500 by default), 01 gives twice that, 10 four times and 11 eight times.
- R4: A rail with captured position c (0 to 30) has its enable rise at the edge that counts the (c·L+1)-th tick after capture, where L is the step length. A rail at position 0 therefore rises on the first tick.
- R5: A rail whose captured position is 31 keeps its enable low for the whole sequence.
- R6: While start stays high, an enable that has risen never falls.
- R7: Done rises at the same edge as the enable of the highest included position. If every rail is excluded, done rises on the first tick.
- R8: Once done is high, every included rail is enabled, and the enables and done hold while start stays high.
- R9: The clock edge that samples start low clears all enables and done and rewinds the timeline. A new sequence needs start to go low for at least one cycle and then high again.
- R10: Clock cycles without a tick do not advance the timeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Sequence request level; high runs the sequence, low clears it |
| speed_i | input | 2 | Step length select, captured at start |
| codes_i | input | N_RAILS*CODE_W | Per-rail positions; rail i occupies bits [i*CODE_W +: CODE_W] |
| tick_i | input | 1 | One-cycle pulse per microsecond |
| rail_en_o | output | N_RAILS | Registered per-rail enables |
| done_o | output | 1 | Registered sequence-complete flag |

## Verification
The assertions assume three things about the inputs. Start is a level that is held for whole cycles. Tick is a pulse sampled once per clock edge. Reset is synchronous, so the captured positions are defined before any step is evaluated. The stimulus meets these assumptions: every input changes only on the falling clock edge, start is released for at least one cycle before a new sequence begins, and the tick comes from a divider that produces it every cycle or every few cycles. The stimulus also changes the position and speed inputs in the middle of a run. The tick-free and capture-stability properties therefore see the inputs move while the latched state has to stay fixed.

// File: rtl/rss_pkg.sv
package rss_pkg;
  localparam int unsigned SPEED_W = 2;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_HOLD = 2'd2
  } seq_state_e;

  typedef logic [SPEED_W-1:0] speed_t;
endpackage

// File: rtl/rss_slot_timer.sv
module rss_slot_timer
  import rss_pkg::*;
#(
  parameter int unsigned BASE_TICKS = 500,
  parameter int unsigned CODE_W     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              load_i,
  input  speed_t            speed_i,
  input  logic              run_i,
  input  logic              tick_i,
  output logic [CODE_W-1:0] slot_o,
  output logic              step_o
);
  localparam int unsigned MAX_LEN = BASE_TICKS * 8;
  localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1);

  speed_t             speed_q;
  logic [LEN_W-1:0]   len;
  logic [LEN_W-1:0]   sub_q;
  logic [CODE_W-1:0]  slot_q;

  assign len    = LEN_W'(BASE_TICKS) << speed_q;
  assign step_o = run_i && tick_i;
  assign slot_o = slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      speed_q <= '0;
    end else if (load_i) begin
      speed_q <= speed_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      sub_q  <= '0;
      slot_q <= '0;
    end else if (step_o) begin
      if (sub_q == len - 1'b1) begin
        sub_q  <= '0;
        slot_q <= slot_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  // R3: the tick count inside a step stays below the captured step length
  p_sub_in_range_r3: assert property (@(posedge clk) disable iff (rst)
    sub_q < len);

  // R10: with no tick, the timeline keeps its position
  p_no_tick_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!step_o && !clear_i) |=> ($stable(sub_q) && $stable(slot_q)));

  // R2: the speed is only taken when a load is requested
  p_speed_capture_r2: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(speed_q));
endmodule

// File: rtl/rss_rail_gate.sv
module rss_rail_gate #(
  parameter int unsigned CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] slot_i,
  output logic              en_o,
  output logic [CODE_W-1:0] code_o,
  output logic              excl_o
);
  localparam logic [CODE_W-1:0] EXCL_CODE = '1;

  logic [CODE_W-1:0] code_q;
  logic              en_q;

  assign excl_o = (code_q == EXCL_CODE);
  assign code_o = code_q;
  assign en_o   = en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= EXCL_CODE;
      en_q   <= 1'b0;
    end else begin
      if (load_i) begin
        code_q <= code_i;
      end
      if (clear_i) begin
        en_q <= 1'b0;
      end else if (step_i && !excl_o && (slot_i >= code_q)) begin
        en_q <= 1'b1;
      end
    end
  end

  // R5: an excluded rail is never enabled
  p_excl_stays_off_r5: assert property (@(posedge clk) disable iff (rst)
    en_q |-> (code_q != EXCL_CODE));

  // R6: a released rail stays on until a clear
  p_en_held_r6: assert property (@(posedge clk) disable iff (rst)
    (!clear_i && en_q) |=> en_q);

  // R2: the captured position only changes on a load
  p_code_capture_r2: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(code_q));
endmodule

// File: rtl/rail_slot_sequencer.sv
module rail_slot_sequencer
  import rss_pkg::*;
#(
  parameter int unsigned N_RAILS    = 6,
  parameter int unsigned CODE_W     = 5,
  parameter int unsigned BASE_TICKS = 500
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_i,
  input  logic [1:0]                speed_i,
  input  logic [N_RAILS*CODE_W-1:0] codes_i,
  input  logic                      tick_i,
  output logic [N_RAILS-1:0]        rail_en_o,
  output logic                      done_o
);
  localparam int unsigned CODES_W = N_RAILS * CODE_W;

  seq_state_e          state_q, state_d;
  logic                clr, load, run, step, last_step;
  logic [CODE_W-1:0]   slot;
  logic [CODE_W-1:0]   max_code;
  logic [N_RAILS-1:0]  en_vec, excl_vec;
  logic [CODES_W-1:0]  code_cap;
  logic                done_q;

  assign clr  = !start_i || (state_q == SEQ_IDLE);
  assign load = start_i && (state_q == SEQ_IDLE);
  assign run  = start_i && (state_q == SEQ_RUN);

  rss_slot_timer #(
    .BASE_TICKS (BASE_TICKS),
    .CODE_W     (CODE_W)
  ) timer_i (
    .clk     (clk),
    .rst     (rst),
    .clear_i (clr),
    .load_i  (load),
    .speed_i (speed_t'(speed_i)),
    .run_i   (run),
    .tick_i  (tick_i),
    .slot_o  (slot),
    .step_o  (step)
  );

  for (genvar g = 0; g < N_RAILS; g++) begin : g_rail
    rss_rail_gate #(
      .CODE_W (CODE_W)
    ) gate_i (
      .clk     (clk),
      .rst     (rst),
      .load_i  (load),
      .clear_i (clr),
      .step_i  (step),
      .code_i  (codes_i[g*CODE_W +: CODE_W]),
      .slot_i  (slot),
      .en_o    (en_vec[g]),
      .code_o  (code_cap[g*CODE_W +: CODE_W]),
      .excl_o  (excl_vec[g])
    );
  end

  // highest included position; zero when every rail is excluded
  always_comb begin
    max_code = '0;
    for (int i = 0; i < N_RAILS; i++) begin
      if (!excl_vec[i] && (code_cap[i*CODE_W +: CODE_W] > max_code)) begin
        max_code = code_cap[i*CODE_W +: CODE_W];
      end
    end
  end

  assign last_step = step && (slot >= max_code);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (start_i) state_d = SEQ_RUN;
      SEQ_RUN: begin
        if (!start_i)       state_d = SEQ_IDLE;
        else if (last_step) state_d = SEQ_HOLD;
      end
      SEQ_HOLD: if (!start_i) state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (clr)            done_q <= 1'b0;
      else if (last_step) done_q <= 1'b1;
    end
  end

  assign rail_en_o = en_vec;
  assign done_o    = done_q;

  // R9: a low start clears every output at the next edge
  p_stop_clears_r9: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> ((rail_en_o == '0) && !done_o));

  // R8: completion implies that every included rail is on
  p_done_all_on_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ((rail_en_o | excl_vec) == '1));

  // R8: completion holds while start stays high
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (start_i && done_o) |=> done_o);

  // R1: nothing is released while the block is idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_IDLE) |-> ((rail_en_o == '0) && !done_o));
endmodule

// File: tb/rail_slot_sequencer_tb_top.sv
module rail_slot_sequencer_tb_top;
  localparam int N    = 6;
  localparam int CW   = 5;
  localparam int BASE = 3;

  typedef struct {
    int           tick_no;
    logic [N-1:0] en;
    logic         done;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic            tick = 1'b0;
  logic [1:0]      speed = 2'b00;
  logic [N*CW-1:0] codes = '1;
  logic [N-1:0]    rail_en;
  logic            done;

  exp_t  q[$];
  exp_t  cur;
  int    n_run = 0, n_fail = 0;
  int    elapsed = 0;
  bit    armed = 1'b0;
  bit    mon_on = 1'b0;
  bit    finished = 1'b0;
  int    tick_period = 1;
  int    tdiv = 0;
  string scen = "R1";

  rail_slot_sequencer #(
    .N_RAILS    (N),
    .CODE_W     (CW),
    .BASE_TICKS (BASE)
  ) dut_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start),
    .speed_i   (speed),
    .codes_i   (codes),
    .tick_i    (tick),
    .rail_en_o (rail_en),
    .done_o    (done)
  );

  always #10 clk = ~clk;

  // tick divider, driven away from the active edge
  always @(negedge clk) begin
    tdiv = (tdiv + 1 >= tick_period) ? 0 : tdiv + 1;
    tick = (tdiv == 0);
  end

  // bench-side count of ticks since capture
  always @(posedge clk) begin
    if (rst || !start) begin
      armed   = 1'b0;
      elapsed = 0;
    end else if (!armed) begin
      armed   = 1'b1;
      elapsed = 0;
    end else if (tick) begin
      elapsed++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
    end
  endtask

  // monitor: pops expected items as ticks pass and compares
  always @(negedge clk) begin
    if (mon_on && !finished) begin
      if (!armed) begin
        chk(rail_en == '0, {scen, " R1 R9 idle enables"}, rail_en, '0);
        chk(done == 1'b0, {scen, " R1 R9 idle done"}, {{(N-1){1'b0}}, done}, '0);
      end else begin
        while (q.size() > 0 && q[0].tick_no <= elapsed) cur = q.pop_front();
        chk(rail_en == cur.en, {scen, " R4 R5 R6 enables"}, rail_en, cur.en);
        chk(done == cur.done, {scen, " R7 R8 done"}, {{(N-1){1'b0}}, done}, {{(N-1){1'b0}}, cur.done});
      end
    end
  end

  // driver: pushes the expected timeline, then runs the sequence
  task automatic run_seq(input logic [N*CW-1:0] c, input logic [1:0] sp, input int period,
                         input bit mutate, input int abort_cyc, input string req);
    int len, maxc, cyc;
    exp_t it;
    len  = BASE << sp;
    maxc = 0;
    for (int r = 0; r < N; r++) begin
      int cr = int'(c[r*CW +: CW]);
      if (cr != 31 && cr > maxc) maxc = cr;
    end
    q.delete();
    it.tick_no = 0; it.en = '0; it.done = 1'b0;
    q.push_back(it);
    for (int k = 0; k <= 30; k++) begin
      it.tick_no = k * len + 1;
      it.en = '0;
      for (int r = 0; r < N; r++) begin
        int cr = int'(c[r*CW +: CW]);
        if (cr != 31 && cr <= k) it.en[r] = 1'b1;
      end
      it.done = (k >= maxc);
      q.push_back(it);
    end
    @(negedge clk);
    scen = req;
    tick_period = period;
    codes = c;
    speed = sp;
    start = 1'b1;
    cyc = (abort_cyc > 0) ? abort_cyc : (maxc * len + 2) * period + 6;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      if (mutate && k == 3) begin
        codes = ~c;
        speed = ~sp;
      end
    end
    start = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mon_on = 1'b1;
    repeat (2) @(negedge clk);
    // R3 R4: one rail per step, shortest step
    run_seq({5'd5, 5'd4, 5'd3, 5'd2, 5'd1, 5'd0}, 2'b00, 1, 1'b0, 0, "R3 R4 speed00");
    // R5 R6: excluded rails and shared positions
    run_seq({5'd31, 5'd2, 5'd2, 5'd31, 5'd7, 5'd0}, 2'b01, 1, 1'b0, 0, "R5 R6 speed01");
    // R10: sparse ticks stretch the timeline
    run_seq({5'd9, 5'd1, 5'd20, 5'd4, 5'd31, 5'd3}, 2'b10, 3, 1'b0, 0, "R10 speed10");
    // R3 R7: longest step, highest position 30
    run_seq({5'd30, 5'd0, 5'd15, 5'd29, 5'd1, 5'd30}, 2'b11, 1, 1'b0, 0, "R3 R7 speed11");
    // R7: every rail excluded
    run_seq({N{5'd31}}, 2'b00, 1, 1'b0, 0, "R7 all excluded");
    // R2: inputs change after capture
    run_seq({5'd6, 5'd0, 5'd31, 5'd3, 5'd1, 5'd5}, 2'b01, 2, 1'b1, 0, "R2 mutate");
    // R9: abort mid-run, then restart
    run_seq({5'd8, 5'd6, 5'd4, 5'd2, 5'd0, 5'd10}, 2'b01, 1, 1'b0, 30, "R9 abort");
    run_seq({5'd1, 5'd1, 5'd0, 5'd0, 5'd2, 5'd31}, 2'b00, 1, 1'b0, 0, "R9 R8 restart");
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule